// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is one 32-bit register on a simple register bus. It records why the chip last came out of reset, and it lets software ask for a new reset. Five bits at the top of the word matter. Bit 31 flags a power-on reset. Bit 30 is the soft power-on command. Bit 29 is the soft externally-initiated reset command. Bit 28 captures a button power-on request, and bit 27 captures a button externally-initiated request. Every lower bit is dropped on a write and reads as zero.

An internal counter tracks reset events so the block can tell the first reset from later ones. The first reset event after power-up, or after a soft power-on command, leaves only bit 31 set. Any later reset event leaves the register alone. Writing either command bit raises a one-cycle request pulse toward the system reset logic. The soft power-on command also rewinds the counter, so the reset that follows is reported as a power-on again. The status bits clear when software writes a one to them. The command bits set when software writes a one to them and cannot be cleared by a write.

The register is decoded at the upper word of an eight-byte slot. At the default base of 0xF020 that is address 0xF024. The lower word and every other address read zero and ignore writes.

Top module: `rst_cause_reg`

## Requirements
- R1: While `pwr_rst_n` is low, and right after it is released, `rdata` is 0 and `rst_req` is 0. A read of the register then returns 0.
- R2: A `sys_rst` cycle with the reset counter at zero loads the register with exactly 0x80000000. A `sys_rst` cycle with a nonzero counter leaves the register unchanged. Each `sys_rst` cycle advances the counter.
- R3: The reset counter saturates at its maximum. It never wraps to zero, so a long run of reset events never sets bit 31 again on its own.
- R4: Write data is masked with 0xF8000000. Bits 26 to 0 always read zero.
- R5: Bits 31, 28 and 27 clear when written with one. Writing zero to them leaves them unchanged.
- R6: Bits 30 and 29 set when written with one. Writing zero never clears them.
- R7: A write with bit 30 set has three effects: `rst_req` is high for exactly the next cycle, bit 30 is set, and the counter returns to zero, so the next `sys_rst` loads 0x80000000.
- R8: A write with bit 29 set and bit 30 clear has three effects: `rst_req` is high for the next cycle, bit 29 is set, and the counter is kept, so a later `sys_rst` leaves the register unchanged.
- R9: A pulse on `btn_por_evt` sets bit 28 and a pulse on `btn_xir_evt` sets bit 27. Each bit stays set until it is cleared by a write. If a button event and a clearing write of the same bit fall in the same cycle, the bit ends up set.
- R10: Only the address whose bits above bit 2 equal the base and whose bit 2 is one (0xF024 by default) accepts writes or returns data. Any other address, the lower word included, reads 0 and ignores writes.
- R11: `rdata` shows the register value one cycle after a cycle with `rd_en` high at the register address. A read in the same cycle as a write returns the value from before the write. `rdata` is 0 in the cycle after any other cycle.
- R12: A write in the same cycle as `sys_rst` is ignored. It does not change the register, does not touch the counter, and raises no `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Asynchronous power-up clear, active low; zeroes register, counter and outputs |
| sys_rst | input | 1 | One cycle high marks one system reset event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| btn_por_evt | input | 1 | Button power-on request event |
| btn_xir_evt | input | 1 | Button externally-initiated reset event |
| rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Two pairs of functions can land in the same cycle.

- **Button event and clearing write.** A button event and a write that clears the same status bit can coincide. The bench drives `btn_por_evt` in the same cycle as a write of 0x10000000 and expects bit 28 still set on the next read.
- **Reset event and write.** A reset event and a software write can coincide. The bench writes the soft power-on command in a `sys_rst` cycle and expects three things: no request pulse, no bit 30 in the next read, and a counter that was not rewound.

The bench's reference model predicts `rdata` and `rst_req` for every cycle, and the outputs are compared against it each clock.

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hF020
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              btn_por_evt,
  input  logic              btn_xir_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);
  localparam int B_POR  = DATA_W - 1;
  localparam int B_SPOR = DATA_W - 2;
  localparam int B_SXIR = DATA_W - 3;
  localparam int B_BPOR = DATA_W - 4;
  localparam int B_BXIR = DATA_W - 5;
  localparam logic [DATA_W-1:0] ONE    = 1;
  localparam logic [DATA_W-1:0] W1C_M  = (ONE << B_POR) | (ONE << B_BPOR) | (ONE << B_BXIR);
  localparam logic [DATA_W-1:0] SET_M  = (ONE << B_SPOR) | (ONE << B_SXIR);
  localparam logic [DATA_W-1:0] KEEP_M = W1C_M | SET_M;
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [DATA_W-1:0] stat, stat_nx, wm;
  logic [CNT_W-1:0]  cnt;
  logic              hit, wr_ok;

  assign hit   = (addr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3]) && addr[2];
  assign wr_ok = wr_en && hit && !sys_rst;
  assign wm    = wdata & KEEP_M;

  always_comb begin
    stat_nx = stat;
    if (sys_rst) begin
      if (cnt == '0) stat_nx = ONE << B_POR;
    end else if (wr_ok) begin
      stat_nx = (stat & ~(wm & W1C_M)) | (wm & SET_M);
    end
    if (btn_por_evt) stat_nx[B_BPOR] = 1'b1;
    if (btn_xir_evt) stat_nx[B_BXIR] = 1'b1;
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      stat    <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
      rdata   <= '0;
    end else begin
      stat    <= stat_nx;
      rst_req <= wr_ok && (wm[B_SPOR] || wm[B_SXIR]);
      rdata   <= (rd_en && hit) ? stat : '0;
      if (sys_rst) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else if (wr_ok && wm[B_SPOR]) begin
        cnt <= '0;
      end
    end
  end

  // R2
  first_load_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && cnt == '0 && !btn_por_evt && !btn_xir_evt) |=> (stat == (ONE << B_POR)));

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_en && hit && !sys_rst && wdata[B_POR]) |=> !stat[B_POR]);

  // R9
  btn_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    btn_por_evt |=> stat[B_BPOR]);

  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_req |-> $past(wr_en && hit && !sys_rst && (wdata[B_SPOR] || wdata[B_SXIR])));

  // R12
  rst_beats_write_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    sys_rst |=> !rst_req);
endmodule

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;
  localparam logic [15:0] A_HI = 16'hF024;
  localparam logic [15:0] A_LO = 16'hF020;

  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic sys_rst = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic btn_por_evt = 1'b0, btn_xir_evt = 1'b0;
  logic [31:0] rdata;
  logic rst_req;

  int total = 0;
  int bad = 0;
  logic [31:0] m_reg = '0;
  int m_cnt = 0;
  logic [31:0] e_rd = '0;
  logic e_req = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_reg #(.ADDR_W(16), .DATA_W(32), .CNT_W(CW), .REG_BASE(16'hF020)) uut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst(sys_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .btn_por_evt(btn_por_evt), .btn_xir_evt(btn_xir_evt),
    .rdata(rdata), .rst_req(rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input string req, input logic w, input logic r, input logic [15:0] a,
                     input logic [31:0] d, input logic sr, input logic bp, input logic bx);
    logic [31:0] dm;
    wr_en = w; rd_en = r; addr = a; wdata = d; sys_rst = sr;
    btn_por_evt = bp; btn_xir_evt = bx;
    e_rd  = (r && a == A_HI) ? m_reg : 32'h0;
    dm    = d & 32'hF800_0000;
    e_req = w && a == A_HI && !sr && (dm[30] || dm[29]);
    if (sr) begin
      if (m_cnt == 0) m_reg = 32'h8000_0000;
      if (m_cnt < CMAX) m_cnt = m_cnt + 1;
    end else if (w && a == A_HI) begin
      m_reg = m_reg & ~(dm & 32'h9800_0000);
      m_reg = m_reg | (dm & 32'h6000_0000);
      if (dm[30]) m_cnt = 0;
    end
    if (bp) m_reg[28] = 1'b1;
    if (bx) m_reg[27] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({req, " rdata"}, rdata, e_rd);
    chk({req, " rst_req"}, {31'h0, rst_req}, {31'h0, e_req});
  endtask

  task automatic idle(input string req);
    cyc(req, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic wr(input string req, input logic [15:0] a, input logic [31:0] d);
    cyc(req, 1'b1, 1'b0, a, d, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic rd(input string req, input logic [15:0] a);
    cyc(req, 1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0, 1'b0);
    idle(req);
  endtask
  task automatic rst_evt(input string req);
    cyc(req, 1'b0, 1'b0, 16'h0, 32'h0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held clear during power-up clear
    chk("R1 rdata in clear", rdata, 32'h0);
    chk("R1 rst_req in clear", {31'h0, rst_req}, 32'h0);
    pwr_rst_n = 1'b1;
    idle("R1");
    rd("R1", A_HI);
    // R2 first event loads, second leaves unchanged
    rst_evt("R2");
    rd("R2", A_HI);
    rst_evt("R2");
    rd("R2", A_HI);
    // R10 other addresses ignored
    wr("R10", A_LO, 32'hFFFF_FFFF);
    wr("R10", 16'h1234, 32'hFFFF_FFFF);
    rd("R10", A_HI);
    rd("R10", A_LO);
    rd("R10", 16'h1234);
    // R4 low bits masked
    wr("R4", A_HI, 32'h07FF_FFFF);
    rd("R4", A_HI);
    // R9 button capture
    cyc("R9", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    cyc("R9", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    rd("R9", A_HI);
    // R5 writing zero keeps, writing one clears
    wr("R5", A_HI, 32'h0);
    rd("R5", A_HI);
    wr("R5", A_HI, 32'h0800_0000);
    rd("R5", A_HI);
    // R9 set wins over clear in same cycle
    cyc("R9", 1'b1, 1'b0, A_HI, 32'h1000_0000, 1'b0, 1'b1, 1'b0);
    rd("R9", A_HI);
    // R11 read in same cycle as write returns old value
    cyc("R11", 1'b1, 1'b1, A_HI, 32'h1000_0000, 1'b0, 1'b0, 1'b0);
    idle("R11");
    rd("R11", A_HI);
    // R8 soft XIR keeps counter
    wr("R8", A_HI, 32'h2000_0000);
    idle("R8");
    rd("R8", A_HI);
    rst_evt("R8");
    rd("R8", A_HI);
    // R6 command bits survive zero write
    wr("R6", A_HI, 32'h0);
    rd("R6", A_HI);
    // R7 soft power-on rewinds counter
    wr("R7", A_HI, 32'h4000_0000);
    idle("R7");
    rd("R7", A_HI);
    rst_evt("R7");
    rd("R7", A_HI);
    // R7 back-to-back commands give back-to-back pulses
    wr("R7", A_HI, 32'h2000_0000);
    wr("R8", A_HI, 32'h2000_0000);
    idle("R8");
    // R12 write in reset cycle ignored
    cyc("R12", 1'b1, 1'b0, A_HI, 32'hC000_0000, 1'b1, 1'b0, 1'b0);
    idle("R12");
    rd("R12", A_HI);
    rst_evt("R12");
    rd("R12", A_HI);
    // R3 counter saturates
    wr("R3", A_HI, 32'h8000_0000);
    for (int i = 0; i < CMAX + 40; i++) rst_evt("R3");
    rd("R3", A_HI);
    wr("R3", A_HI, 32'h4000_0000);
    rst_evt("R3");
    rd("R3", A_HI);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule